// File: doc/BRIEF.md
# Remote Register Access Port

This block serves register reads and writes that neighbouring cores issue against a family of threads. Each request carries a family number, a register kind and a logical register number. The block sends these three values to an external allocator lookup in the same cycle. The lookup returns a physical register number, the register's type (integer or float), and a flag that says whether the mapping exists. Only after this translation does the block touch the register file.

A write needs the register file's asynchronous write port. If that port is denied, the request stalls until the port is granted. If the translation has no valid mapping, the write completes at once and the register file is left alone. A read needs the asynchronous read port. If that port is denied, the read is not accepted and the requester presents it again. A granted read produces a response one cycle later. When the stored register is not in the full state, the response is a full zero of the register's type instead of the stored contents.

Requests use a valid/ready handshake, and the block accepts at most one per cycle. The allocator table and the network transport both sit outside the block.

Top module: `remote_reg_port`

## Requirements
- R1: In every cycle, the lookup outputs carry the request's family, kind and logical number. Any register-file access uses the physical number and type returned by that lookup.
- R2: A write (op bit 1) with a valid mapping raises the write-port request with the translated type, index and write data. It is accepted (ready high) exactly when the write grant is high.
- R3: A write whose grant is low is not accepted. The request stays pending, and the register is not written until a later cycle in which the grant is high.
- R4: A write with no valid mapping is accepted at once. It raises no write-port request, so the register file is left unchanged.
- R5: A read (op bit 0) with a valid mapping raises the read-port request with the translated type and index. It is accepted exactly when the read grant is high, and the response is valid in the cycle after acceptance.
- R6: A read whose grant is low is not accepted, and no response follows in the next cycle.
- R7: A granted read of a register whose full flag is set returns the stored data, together with the register's type (type 0 = integer, 1 = float).
- R8: A granted read of a register whose full flag is clear returns data zero, which is the encoding of integer 0 and of float +0.0, together with the register's type.
- R9: A read with no valid mapping is accepted at once without a port request. It responds one cycle later with integer type and data zero.
- R10: While reset is active, and in the first cycle after it, the response valid output is low.
- R11: With no request valid, neither port request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted this cycle |
| req_op_i | input | 1 | 1 = write, 0 = read |
| req_fid_i | input | FID_W | Family number |
| req_kind_i | input | 2 | Remote register kind |
| req_laddr_i | input | LADDR_W | Logical register number |
| req_wdata_i | input | DATA_W | Write data |
| lk_fid_o | output | FID_W | Lookup family |
| lk_kind_o | output | 2 | Lookup kind |
| lk_laddr_o | output | LADDR_W | Lookup logical number |
| lk_ok_i | input | 1 | Lookup found a mapping |
| lk_type_i | input | 1 | Looked-up register type |
| lk_idx_i | input | PIDX_W | Looked-up physical index |
| wr_req_o | output | 1 | Write port request |
| wr_gnt_i | input | 1 | Write port grant |
| wr_type_o | output | 1 | Write register type |
| wr_idx_o | output | PIDX_W | Write physical index |
| wr_data_o | output | DATA_W | Write data |
| rd_req_o | output | 1 | Read port request |
| rd_gnt_i | input | 1 | Read port grant |
| rd_type_o | output | 1 | Read register type |
| rd_idx_o | output | PIDX_W | Read physical index |
| rd_data_i | input | DATA_W | Read data, same cycle as grant |
| rd_full_i | input | 1 | Read register is full |
| rsp_valid_o | output | 1 | Read response valid |
| rsp_type_o | output | 1 | Response register type |
| rsp_data_o | output | DATA_W | Response data |

## Verification
The bench builds the block with its default parameters: a 4-bit family number, 5-bit logical numbers, 7-bit physical indices and 64-bit data. Its allocator model treats family 15 as unmapped, which exercises the drop and zero-reply paths. The model also derives the type from a logical-number bit, so both register banks are reached. The bench preloads the register file with full and non-full entries. It then writes some of the non-full entries and reads them back, so stalls, retries, back-to-back reads and typed-zero replies all occur.

// File: rtl/rrap_pkg.sv
package rrap_pkg;
  typedef enum logic {OP_READ = 1'b0, OP_WRITE = 1'b1} rrap_op_e;
  typedef enum logic {RT_INT = 1'b0, RT_FLT = 1'b1} rrap_type_e;
endpackage

// File: rtl/rrap_xlat.sv
module rrap_xlat #(
  parameter int FID_W   = 4,
  parameter int LADDR_W = 5,
  parameter int PIDX_W  = 7
) (
  input  logic               req_valid_i,
  input  logic [FID_W-1:0]   req_fid_i,
  input  logic [1:0]         req_kind_i,
  input  logic [LADDR_W-1:0] req_laddr_i,
  output logic [FID_W-1:0]   lk_fid_o,
  output logic [1:0]         lk_kind_o,
  output logic [LADDR_W-1:0] lk_laddr_o,
  input  logic               lk_ok_i,
  input  logic               lk_type_i,
  input  logic [PIDX_W-1:0]  lk_idx_i,
  output logic               hit_o,
  output logic               type_o,
  output logic [PIDX_W-1:0]  idx_o
);
  assign lk_fid_o   = req_fid_i;
  assign lk_kind_o  = req_kind_i;
  assign lk_laddr_o = req_laddr_i;
  // a mapping only counts for a live request
  assign hit_o  = req_valid_i & lk_ok_i;
  assign type_o = lk_type_i;
  assign idx_o  = lk_idx_i;
endmodule

// File: rtl/rrap_ctrl.sv
module rrap_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic req_op_i,
  input  logic hit_i,
  input  logic wr_gnt_i,
  input  logic rd_gnt_i,
  output logic wr_req_o,
  output logic rd_req_o,
  output logic ready_o,
  output logic rd_fire_o
);
  import rrap_pkg::*;
  logic is_wr;
  assign is_wr    = (req_op_i == OP_WRITE);
  assign wr_req_o = req_valid_i & is_wr & hit_i;
  assign rd_req_o = req_valid_i & ~is_wr & hit_i;
  // unmapped requests complete without a port
  assign ready_o  = req_valid_i & (is_wr ? (~hit_i | wr_gnt_i) : (~hit_i | rd_gnt_i));
  assign rd_fire_o = ready_o & ~is_wr;

  a_r11_idle_no_port: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> !wr_req_o && !rd_req_o);
  a_r4_unmapped_wr_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && is_wr && !hit_i |-> ready_o && !wr_req_o);
  a_r3_stall_no_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o && !wr_gnt_i |-> !ready_o);
endmodule

// File: rtl/rrap_rsp.sv
module rrap_rsp #(
  parameter int DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic              hit_i,
  input  logic              type_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              rd_full_i,
  output logic              rsp_valid_o,
  output logic              rsp_type_o,
  output logic [DATA_W-1:0] rsp_data_o
);
  import rrap_pkg::*;
  logic              nxt_type;
  logic [DATA_W-1:0] nxt_data;

  always_comb begin
    nxt_type = hit_i ? type_i : RT_INT;
    // zero bits encode both integer 0 and float +0.0
    nxt_data = (hit_i && rd_full_i) ? rd_data_i : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_type_o  <= 1'b0;
      rsp_data_o  <= '0;
    end else begin
      rsp_valid_o <= fire_i;
      if (fire_i) begin
        rsp_type_o <= nxt_type;
        rsp_data_o <= nxt_data;
      end
    end
  end

  a_r5_rsp_after_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> rsp_valid_o);
  a_r6_no_fire_no_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire_i |=> !rsp_valid_o);
  a_r8_empty_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i && !rd_full_i |=> rsp_data_o == '0);
endmodule

// File: rtl/remote_reg_port.sv
module remote_reg_port #(
  parameter int FID_W   = 4,
  parameter int LADDR_W = 5,
  parameter int PIDX_W  = 7,
  parameter int DATA_W  = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic               req_op_i,
  input  logic [FID_W-1:0]   req_fid_i,
  input  logic [1:0]         req_kind_i,
  input  logic [LADDR_W-1:0] req_laddr_i,
  input  logic [DATA_W-1:0]  req_wdata_i,
  output logic [FID_W-1:0]   lk_fid_o,
  output logic [1:0]         lk_kind_o,
  output logic [LADDR_W-1:0] lk_laddr_o,
  input  logic               lk_ok_i,
  input  logic               lk_type_i,
  input  logic [PIDX_W-1:0]  lk_idx_i,
  output logic               wr_req_o,
  input  logic               wr_gnt_i,
  output logic               wr_type_o,
  output logic [PIDX_W-1:0]  wr_idx_o,
  output logic [DATA_W-1:0]  wr_data_o,
  output logic               rd_req_o,
  input  logic               rd_gnt_i,
  output logic               rd_type_o,
  output logic [PIDX_W-1:0]  rd_idx_o,
  input  logic [DATA_W-1:0]  rd_data_i,
  input  logic               rd_full_i,
  output logic               rsp_valid_o,
  output logic               rsp_type_o,
  output logic [DATA_W-1:0]  rsp_data_o
);
  logic              hit, ptype, rd_fire;
  logic [PIDX_W-1:0] pidx;

  rrap_xlat #(.FID_W(FID_W), .LADDR_W(LADDR_W), .PIDX_W(PIDX_W)) u_xlat (
    .req_valid_i(req_valid_i), .req_fid_i(req_fid_i), .req_kind_i(req_kind_i),
    .req_laddr_i(req_laddr_i), .lk_fid_o(lk_fid_o), .lk_kind_o(lk_kind_o),
    .lk_laddr_o(lk_laddr_o), .lk_ok_i(lk_ok_i), .lk_type_i(lk_type_i),
    .lk_idx_i(lk_idx_i), .hit_o(hit), .type_o(ptype), .idx_o(pidx)
  );

  rrap_ctrl u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_op_i(req_op_i),
    .hit_i(hit), .wr_gnt_i(wr_gnt_i), .rd_gnt_i(rd_gnt_i), .wr_req_o(wr_req_o),
    .rd_req_o(rd_req_o), .ready_o(req_ready_o), .rd_fire_o(rd_fire)
  );

  assign wr_type_o = ptype;
  assign wr_idx_o  = pidx;
  assign wr_data_o = req_wdata_i;
  assign rd_type_o = ptype;
  assign rd_idx_o  = pidx;

  rrap_rsp #(.DATA_W(DATA_W)) u_rsp (
    .clk_i(clk_i), .rst_ni(rst_ni), .fire_i(rd_fire), .hit_i(hit), .type_i(ptype),
    .rd_data_i(rd_data_i), .rd_full_i(rd_full_i), .rsp_valid_o(rsp_valid_o),
    .rsp_type_o(rsp_type_o), .rsp_data_o(rsp_data_o)
  );

  a_r2_wr_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |-> req_valid_i && lk_ok_i);
  a_r9_unmapped_rd_no_port: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !req_op_i && !lk_ok_i |-> !rd_req_o && req_ready_o);
  a_r1_lookup_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> lk_fid_o == req_fid_i && lk_laddr_o == req_laddr_i);
endmodule

// File: tb/remote_reg_port_bench.sv
module remote_reg_port_bench;
  localparam int FID_W = 4, LADDR_W = 5, PIDX_W = 7, DATA_W = 64;
  localparam int NREG = 1 << PIDX_W;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic req_valid, req_ready, req_op;
  logic [FID_W-1:0] req_fid;
  logic [1:0] req_kind;
  logic [LADDR_W-1:0] req_laddr;
  logic [DATA_W-1:0] req_wdata;
  logic [FID_W-1:0] lk_fid;
  logic [1:0] lk_kind;
  logic [LADDR_W-1:0] lk_laddr;
  logic lk_ok, lk_type;
  logic [PIDX_W-1:0] lk_idx;
  logic wr_req, wr_gnt, wr_type, rd_req, rd_gnt, rd_type, rd_full;
  logic [PIDX_W-1:0] wr_idx, rd_idx;
  logic [DATA_W-1:0] wr_data, rd_data;
  logic rsp_valid, rsp_type;
  logic [DATA_W-1:0] rsp_data;

  logic [DATA_W-1:0] rf_val [2][NREG];
  logic              rf_full[2][NREG];

  int total = 0, bad = 0;
  bit done = 0;

  remote_reg_port #(.FID_W(FID_W), .LADDR_W(LADDR_W), .PIDX_W(PIDX_W), .DATA_W(DATA_W))
  u_remote_reg_port (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_op_i(req_op), .req_fid_i(req_fid), .req_kind_i(req_kind), .req_laddr_i(req_laddr),
    .req_wdata_i(req_wdata), .lk_fid_o(lk_fid), .lk_kind_o(lk_kind), .lk_laddr_o(lk_laddr),
    .lk_ok_i(lk_ok), .lk_type_i(lk_type), .lk_idx_i(lk_idx), .wr_req_o(wr_req),
    .wr_gnt_i(wr_gnt), .wr_type_o(wr_type), .wr_idx_o(wr_idx), .wr_data_o(wr_data),
    .rd_req_o(rd_req), .rd_gnt_i(rd_gnt), .rd_type_o(rd_type), .rd_idx_o(rd_idx),
    .rd_data_i(rd_data), .rd_full_i(rd_full), .rsp_valid_o(rsp_valid),
    .rsp_type_o(rsp_type), .rsp_data_o(rsp_data)
  );

  // allocator model: family 15 unmapped, type from laddr[4]
  function automatic logic m_ok(input logic [FID_W-1:0] f); return f != 4'hF; endfunction
  function automatic logic m_type(input logic [LADDR_W-1:0] a); return a[4]; endfunction
  function automatic logic [PIDX_W-1:0] m_idx(input logic [FID_W-1:0] f, input logic [1:0] k,
                                               input logic [LADDR_W-1:0] a);
    return {f[2:0], k, a[1:0]};
  endfunction

  always_comb begin
    lk_ok   = m_ok(lk_fid);
    lk_type = m_type(lk_laddr);
    lk_idx  = m_idx(lk_fid, lk_kind, lk_laddr);
    rd_data = rf_val[rd_type][rd_idx];
    rd_full = rf_full[rd_type][rd_idx];
  end

  task automatic chk(input bit ok, input string req, input logic [DATA_W-1:0] act,
                     input logic [DATA_W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  bit pend_v = 0, pend_t = 0;
  logic [DATA_W-1:0] pend_d = '0;

  // one cycle: check last response, drive new request, check combinational side
  task automatic step(input bit v, input bit op, input logic [3:0] f, input logic [1:0] k,
                      input logic [4:0] a, input logic [63:0] wd, input bit wg, input bit rg);
    bit ok, t, exp_rdy;
    logic [PIDX_W-1:0] ix;
    @(negedge clk);
    chk(rsp_valid == pend_v, "R5/R6/R9 rsp_valid", 64'(rsp_valid), 64'(pend_v));
    if (pend_v) begin
      chk(rsp_data == pend_d, "R7/R8/R9 rsp_data", rsp_data, pend_d);
      chk(rsp_type == pend_t, "R7/R8 rsp_type", 64'(rsp_type), 64'(pend_t));
    end
    req_valid = v; req_op = op; req_fid = f; req_kind = k; req_laddr = a; req_wdata = wd;
    wr_gnt = wg; rd_gnt = rg;
    #1;
    ok = m_ok(f); t = m_type(a); ix = m_idx(f, k, a);
    exp_rdy = v && (op ? (!ok || wg) : (!ok || rg));
    chk(req_ready == exp_rdy, "R2/R3/R4/R5 ready", 64'(req_ready), 64'(exp_rdy));
    chk(wr_req == (v && op && ok), "R2/R4/R11 wr_req", 64'(wr_req), 64'(v && op && ok));
    chk(rd_req == (v && !op && ok), "R5/R9/R11 rd_req", 64'(rd_req), 64'(v && !op && ok));
    if (v && ok && op)
      chk({wr_type, wr_idx, wr_data} == {t, ix, wd}, "R1 R2 wr addr/data",
          64'({wr_type, wr_idx}), 64'({t, ix}));
    if (v && ok && !op)
      chk({rd_type, rd_idx} == {t, ix}, "R1 R5 rd addr", 64'({rd_type, rd_idx}), 64'({t, ix}));
    pend_v = v && !op && exp_rdy;
    pend_t = ok ? t : 1'b0;
    pend_d = (ok && rf_full[t][ix]) ? rf_val[t][ix] : '0;
    if (v && op && ok && wg) begin
      rf_val[t][ix] = wd; rf_full[t][ix] = 1'b1;
    end
  endtask

  typedef struct packed {
    logic v; logic op; logic [3:0] f; logic [1:0] k; logic [4:0] a;
    logic [63:0] wd; logic wg; logic rg;
  } vec_t;

  localparam vec_t VECS [14] = '{
    '{1'b1, 1'b0, 4'h1, 2'd0, 5'h00, 64'h0, 1'b0, 1'b1},   // R7 full int
    '{1'b1, 1'b0, 4'h1, 2'd0, 5'h01, 64'h0, 1'b0, 1'b1},   // R8 empty int
    '{1'b1, 1'b0, 4'h2, 2'd1, 5'h13, 64'h0, 1'b0, 1'b1},   // R8 empty float
    '{1'b1, 1'b0, 4'h2, 2'd1, 5'h12, 64'h0, 1'b0, 1'b1},   // R7 full float
    '{1'b1, 1'b0, 4'h3, 2'd2, 5'h01, 64'h0, 1'b1, 1'b0},   // R6 denied
    '{1'b1, 1'b0, 4'h3, 2'd2, 5'h01, 64'h0, 1'b0, 1'b1},   // R6 retry granted
    '{1'b1, 1'b1, 4'h3, 2'd2, 5'h01, 64'hCAFE_0001, 1'b0, 1'b1}, // R3 stall
    '{1'b1, 1'b1, 4'h3, 2'd2, 5'h01, 64'hCAFE_0001, 1'b1, 1'b0}, // R2 granted
    '{1'b1, 1'b0, 4'h3, 2'd2, 5'h01, 64'h0, 1'b0, 1'b1},   // R7 read back
    '{1'b1, 1'b1, 4'hF, 2'd0, 5'h01, 64'hDEAD, 1'b0, 1'b0}, // R4 unmapped write
    '{1'b1, 1'b0, 4'hF, 2'd3, 5'h11, 64'h0, 1'b0, 1'b0},   // R9 unmapped read
    '{1'b1, 1'b1, 4'h4, 2'd3, 5'h13, 64'h3FF0_0000_0000_0000, 1'b1, 1'b1}, // R2 float
    '{1'b1, 1'b0, 4'h4, 2'd3, 5'h13, 64'h0, 1'b1, 1'b1},   // R7 float back-to-back
    '{1'b0, 1'b0, 4'h4, 2'd3, 5'h13, 64'h0, 1'b1, 1'b1}    // R11 idle with grants
  };

  initial begin
    for (int t = 0; t < 2; t++)
      for (int i = 0; i < NREG; i++) begin
        rf_val[t][i]  = {32'(t), 32'(i)} ^ 64'h5A5A_0000_1234_0000;
        rf_full[t][i] = (i % 2 == 0);
      end
    req_valid = 0; req_op = 0; req_fid = 0; req_kind = 0; req_laddr = 0; req_wdata = 0;
    wr_gnt = 0; rd_gnt = 0;
    #12;
    chk(rsp_valid == 1'b0, "R10 reset rsp_valid", 64'(rsp_valid), 64'h0);
    chk(!wr_req && !rd_req, "R11 reset idle", 64'({wr_req, rd_req}), 64'h0);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R10 after reset", 64'(rsp_valid), 64'h0);
    for (int n = 0; n < 14; n++)
      step(VECS[n].v, VECS[n].op, VECS[n].f, VECS[n].k, VECS[n].a, VECS[n].wd,
           VECS[n].wg, VECS[n].rg);
    // R4: register an unmapped write would alias with stays untouched
    step(1, 1, 4'hF, 2'd1, 5'h03, 64'hBAD, 1, 1);
    step(1, 0, 4'h7, 2'd1, 5'h03, 0, 0, 1);
    // R3: long stall then grant, then read
    for (int s = 0; s < 3; s++) step(1, 1, 4'h5, 2'd0, 5'h15, 64'h77, 0, 0);
    step(1, 1, 4'h5, 2'd0, 5'h15, 64'h77, 1, 0);
    step(1, 0, 4'h5, 2'd0, 5'h15, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule